// File: doc/BRIEF.md
# Replica Way Selection Controller

When the local first-level cache of a tile pushes out a line, this controller decides whether a copy of that line goes into the tile's own second-level slice. If a copy is made, it also decides which way of the addressed set receives it. The copy stays local, so a later miss by the same core can be served without crossing the chip to the line's home slice.

The controller reads the eviction request and the state of every way in the target set. That state is whether the way is valid, whether it holds a replica or a home line, and whether a home line has sharers. One cycle later it returns a registered decision. The decision carries an allocate flag, a one-hot way select, a class code for the chosen way, a flag for overwriting a valid replica, and the address of any valid line being displaced, which goes to the directory side.

Ways fall into four classes, ranked from most to least willing to give up their space: invalid, unshared home, replica, and shared home. Shared home lines are never given up. Among the ways of the winning class, a free-running LFSR sets the start point of a rotating scan. This spreads the choice across the ways.

Top module: `rvs_replica_sel`

## Requirements
- R1: Every cycle with `evict_valid_i` high is followed, one clock later, by exactly one cycle of `dec_valid_o` high. `dec_valid_o` is low in all other cycles.
- R2: An eviction with `evict_capacity_i` low gives `alloc_o` = 0 and `way_class_o` = 2'b11.
- R3: The home tile of a line is `evict_addr_i[HOME_LSB +: TILE_W]`, with a default of bits [8:6]. When it equals `tile_id_i`, the result is `alloc_o` = 0 and `way_class_o` = 2'b11.
- R4: If any way has valid = 0, the chosen way is an invalid way and `way_class_o` = 2'b00.
- R5: If no way is invalid and some valid way has replica = 0 and shared = 0, that kind of way is chosen and `way_class_o` = 2'b01.
- R6: If only replicas (valid = 1, replica = 1) and shared home lines remain, a replica is chosen, `way_class_o` = 2'b10 and `replica_over_o` = 1. `replica_over_o` is 0 for every other result.
- R7: A shared home line (valid = 1, replica = 0, shared = 1) is never selected. When every way is such a line, the result is `alloc_o` = 0, `way_sel_o` = 0 and `way_class_o` = 2'b11.
- R8: `way_sel_o` is one-hot when `alloc_o` = 1 and all-zero when `alloc_o` = 0. Way i is bit i.
- R9: `displace_valid_o` = 1 exactly when the chosen way was valid (class 2'b01 or 2'b10). `displace_addr_o` is then that way's slice of `way_addr_i`, which is bits [i*ADDR_W +: ADDR_W]. Otherwise it is zero.
- R10: Within a class, the way is picked by a rotating scan that starts at an LFSR-driven index. Repeated requests with several candidates therefore choose more than one distinct way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evict_valid_i | input | 1 | First-level eviction request |
| evict_capacity_i | input | 1 | The eviction is caused by capacity |
| evict_addr_i | input | ADDR_W | Address of the evicted line |
| tile_id_i | input | TILE_W | Index of the local tile |
| way_valid_i | input | WAYS | Per-way valid bit |
| way_replica_i | input | WAYS | Per-way flag: the way holds a replica |
| way_shared_i | input | WAYS | Per-way flag: a home line has sharers |
| way_addr_i | input | WAYS*ADDR_W | Per-way line address, with way i at [i*ADDR_W +: ADDR_W] |
| dec_valid_o | output | 1 | Decision valid |
| alloc_o | output | 1 | A replica is to be written |
| way_sel_o | output | WAYS | One-hot target way |
| way_class_o | output | 2 | Class of the chosen way (00, 01, 10), or 11 when there is none |
| replica_over_o | output | 1 | A valid replica is overwritten |
| displace_valid_o | output | 1 | A valid line is displaced |
| displace_addr_o | output | ADDR_W | Address of the displaced line |

## Verification
The bench aims at sets where the winning class has exactly one member hidden among shared home lines. A design with a wrong class order, or one that skips over that way, picks a different way or none at all. It fills sets with nothing but shared home lines, where a design that weakens the protection would wrongly allocate into a shared line. It sends non-capacity and locally homed evictions into sets with free ways, where a faulty design would make a copy anyway. Random set states check class membership and the displaced-address mux, which a design with a wrong index would report from the wrong way. A long run of requests into fully empty sets shows whether the start index really moves.

// File: rtl/rvs_pkg.sv
package rvs_pkg;
  typedef enum logic [1:0] {
    CLS_INV       = 2'b00,
    CLS_HOME_FREE = 2'b01,
    CLS_REPLICA   = 2'b10,
    CLS_NONE      = 2'b11
  } rvs_cls_e;
endpackage

// File: rtl/rvs_lfsr.sv
module rvs_lfsr #(
  parameter int              W     = 16,
  parameter int              OUT_W = 4,
  parameter logic [W-1:0]    TAPS  = 16'hB400,
  parameter logic [W-1:0]    SEED  = 16'h1ACE
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [OUT_W-1:0] rnd_o
);
  logic [W-1:0] state_q;

  // Galois form, free running
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEED;
    else         state_q <= {1'b0, state_q[W-1:1]} ^ (state_q[0] ? TAPS : '0);
  end

  assign rnd_o = state_q[OUT_W-1:0];

  AST_LFSR_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0); // R10
endmodule

// File: rtl/rvs_way_classify.sv
module rvs_way_classify #(
  parameter int WAYS = 16
) (
  input  logic [WAYS-1:0] valid_i,
  input  logic [WAYS-1:0] replica_i,
  input  logic [WAYS-1:0] shared_i,
  output logic [WAYS-1:0] inv_m_o,
  output logic [WAYS-1:0] free_m_o,
  output logic [WAYS-1:0] rep_m_o,
  output logic [WAYS-1:0] prot_m_o
);
  for (genvar g = 0; g < WAYS; g++) begin : g_way
    assign inv_m_o[g]  = ~valid_i[g];
    assign free_m_o[g] = valid_i[g] & ~replica_i[g] & ~shared_i[g];
    assign rep_m_o[g]  = valid_i[g] &  replica_i[g];
    assign prot_m_o[g] = valid_i[g] & ~replica_i[g] &  shared_i[g];
  end
endmodule

// File: rtl/rvs_rot_pick.sv
module rvs_rot_pick #(
  parameter int WAYS  = 16,
  parameter int IDX_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]  mask_i,
  input  logic [IDX_W-1:0] start_i,
  output logic [WAYS-1:0]  pick_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  logic [IDX_W-1:0] pos;
  logic             found;

  // first set bit at or after start_i, wrapping (WAYS is a power of two)
  always_comb begin
    pick_o = '0;
    idx_o  = '0;
    found  = 1'b0;
    pos    = '0;
    for (int i = 0; i < WAYS; i++) begin
      pos = start_i + IDX_W'(i);
      if (!found && mask_i[pos]) begin
        found       = 1'b1;
        pick_o[pos] = 1'b1;
        idx_o       = pos;
      end
    end
  end

  assign any_o = found;
endmodule

// File: rtl/rvs_replica_sel.sv
module rvs_replica_sel
  import rvs_pkg::*;
#(
  parameter int              WAYS      = 16,
  parameter int              ADDR_W    = 32,
  parameter int              TILE_W    = 3,
  parameter int              HOME_LSB  = 6,
  parameter int              LFSR_W    = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'h1ACE
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   evict_valid_i,
  input  logic                   evict_capacity_i,
  input  logic [ADDR_W-1:0]      evict_addr_i,
  input  logic [TILE_W-1:0]      tile_id_i,
  input  logic [WAYS-1:0]        way_valid_i,
  input  logic [WAYS-1:0]        way_replica_i,
  input  logic [WAYS-1:0]        way_shared_i,
  input  logic [WAYS*ADDR_W-1:0] way_addr_i,
  output logic                   dec_valid_o,
  output logic                   alloc_o,
  output logic [WAYS-1:0]        way_sel_o,
  output logic [1:0]             way_class_o,
  output logic                   replica_over_o,
  output logic                   displace_valid_o,
  output logic [ADDR_W-1:0]      displace_addr_o
);
  localparam int IDX_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [WAYS-1:0]   inv_m, free_m, rep_m, prot_m;
  logic [WAYS-1:0]   cand_m, pick;
  logic [IDX_W-1:0]  start_idx, pick_idx;
  logic              pick_any;
  logic [TILE_W-1:0] home_tile;
  logic              want;
  logic              alloc_d;
  rvs_cls_e          cls_d;
  logic              unused_addr;

  rvs_lfsr #(
    .W(LFSR_W), .OUT_W(IDX_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)
  ) u_lfsr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rnd_o (start_idx)
  );

  rvs_way_classify #(.WAYS(WAYS)) u_cls (
    .valid_i  (way_valid_i),
    .replica_i(way_replica_i),
    .shared_i (way_shared_i),
    .inv_m_o  (inv_m),
    .free_m_o (free_m),
    .rep_m_o  (rep_m),
    .prot_m_o (prot_m)
  );

  assign home_tile   = evict_addr_i[HOME_LSB +: TILE_W];
  assign want        = evict_valid_i & evict_capacity_i & (home_tile != tile_id_i);
  assign unused_addr = ^evict_addr_i;

  // strict class priority; shared home lines never enter the candidate set
  always_comb begin
    if (|inv_m)       begin cls_d = CLS_INV;       cand_m = inv_m;  end
    else if (|free_m) begin cls_d = CLS_HOME_FREE; cand_m = free_m; end
    else if (|rep_m)  begin cls_d = CLS_REPLICA;   cand_m = rep_m;  end
    else              begin cls_d = CLS_NONE;      cand_m = '0;     end
  end

  rvs_rot_pick #(.WAYS(WAYS), .IDX_W(IDX_W)) u_pick (
    .mask_i (cand_m),
    .start_i(start_idx),
    .pick_o (pick),
    .idx_o  (pick_idx),
    .any_o  (pick_any)
  );

  assign alloc_d = want & pick_any;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_valid_o      <= 1'b0;
      alloc_o          <= 1'b0;
      way_sel_o        <= '0;
      way_class_o      <= CLS_NONE;
      replica_over_o   <= 1'b0;
      displace_valid_o <= 1'b0;
      displace_addr_o  <= '0;
    end else begin
      dec_valid_o      <= evict_valid_i;
      alloc_o          <= alloc_d;
      way_sel_o        <= alloc_d ? pick : '0;
      way_class_o      <= alloc_d ? cls_d : CLS_NONE;
      replica_over_o   <= alloc_d && (cls_d == CLS_REPLICA);
      displace_valid_o <= alloc_d && (cls_d != CLS_INV);
      displace_addr_o  <= (alloc_d && (cls_d != CLS_INV)) ?
                          way_addr_i[pick_idx*ADDR_W +: ADDR_W] : '0;
    end
  end

  AST_DEC_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evict_valid_i |=> dec_valid_o); // R1
  AST_DEC_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evict_valid_i |=> !dec_valid_o); // R1
  AST_NONCAP_SKIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evict_valid_i && !evict_capacity_i |=> !alloc_o); // R2
  AST_LOCAL_HOME_SKIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evict_valid_i && (evict_addr_i[HOME_LSB +: TILE_W] == tile_id_i) |=> !alloc_o); // R3
  AST_INVALID_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    want && (way_valid_i != '1) |=> alloc_o && (way_class_o == 2'b00)); // R4
  AST_OVER_IS_REPLICA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    replica_over_o |-> alloc_o && (way_class_o == 2'b10)); // R6
  AST_PROTECTED_SAFE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evict_valid_i |=> ((way_sel_o & $past(prot_m)) == '0)); // R7
  AST_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_o |-> $onehot(way_sel_o)); // R8
  AST_SEL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !alloc_o |-> (way_sel_o == '0)); // R8
  AST_DISPLACE_CLASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    displace_valid_o |-> alloc_o && (way_class_o != 2'b00)); // R9
endmodule

// File: tb/tb_rvs_replica_sel.sv
module tb_rvs_replica_sel;
  localparam int WAYS     = 16;
  localparam int ADDR_W   = 32;
  localparam int TILE_W   = 3;
  localparam int HOME_LSB = 6;
  localparam logic [TILE_W-1:0] TILE_ID = 3'd2;

  typedef struct {
    bit                    alloc;
    logic [1:0]            cls;
    logic [WAYS-1:0]       allowed;
    logic [WAYS*ADDR_W-1:0] addrs;
    string                 tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic evict_valid = 1'b0, evict_cap = 1'b0;
  logic [ADDR_W-1:0] evict_addr = '0;
  logic [WAYS-1:0] wv = '0, wr = '0, ws = '0;
  logic [WAYS*ADDR_W-1:0] wa = '0;
  logic dec_valid, alloc, rep_over, disp_valid;
  logic [WAYS-1:0] way_sel;
  logic [1:0] way_cls;
  logic [ADDR_W-1:0] disp_addr;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  exp_t q[$];
  logic [WAYS-1:0] seen = '0;

  always #2.5 clk = ~clk;

  rvs_replica_sel dut (
    .clk_i(clk), .rst_ni(rst_n),
    .evict_valid_i(evict_valid), .evict_capacity_i(evict_cap),
    .evict_addr_i(evict_addr), .tile_id_i(TILE_ID),
    .way_valid_i(wv), .way_replica_i(wr), .way_shared_i(ws), .way_addr_i(wa),
    .dec_valid_o(dec_valid), .alloc_o(alloc), .way_sel_o(way_sel),
    .way_class_o(way_cls), .replica_over_o(rep_over),
    .displace_valid_o(disp_valid), .displace_addr_o(disp_addr)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  // driver: applies one request at a negedge and queues its expectation
  task automatic send(input bit cap, input logic [TILE_W-1:0] home,
                      input logic [WAYS-1:0] v, r, s, input string tag);
    exp_t e;
    logic [WAYS-1:0] inv, fr, rp;
    @(negedge clk);
    evict_valid = 1'b1;
    evict_cap   = cap;
    evict_addr  = $urandom;
    evict_addr[HOME_LSB +: TILE_W] = home;
    wv = v; wr = r; ws = s;
    for (int i = 0; i < WAYS; i++) wa[i*ADDR_W +: ADDR_W] = $urandom;
    inv = ~v; fr = v & ~r & ~s; rp = v & r;
    e.addrs = wa;
    e.tag = tag;
    if (!cap || home == TILE_ID) begin e.alloc = 0; e.cls = 2'b11; e.allowed = '0; end
    else if (|inv) begin e.alloc = 1; e.cls = 2'b00; e.allowed = inv; end
    else if (|fr)  begin e.alloc = 1; e.cls = 2'b01; e.allowed = fr;  end
    else if (|rp)  begin e.alloc = 1; e.cls = 2'b10; e.allowed = rp;  end
    else           begin e.alloc = 0; e.cls = 2'b11; e.allowed = '0;  end
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      evict_valid = 1'b0;
    end
  endtask

  // monitor: compares each decision against the head of the queue
  always @(negedge clk) begin
    if (rst_n && dec_valid && !done) begin
      if (q.size() == 0) begin
        chk(0, "R1 unexpected decision", 1, 0);
      end else begin
        exp_t e;
        int idx;
        e = q.pop_front();
        idx = 0;
        for (int i = 0; i < WAYS; i++) if (way_sel[i]) idx = i;
        chk(alloc == e.alloc, {e.tag, " alloc"}, alloc, e.alloc);
        chk(way_cls == e.cls, {e.tag, " class"}, way_cls, e.cls);
        chk((way_sel & ~e.allowed) == '0, "R7 way outside winning class", way_sel, e.allowed);
        chk($countones(way_sel) == (e.alloc ? 1 : 0), "R8 select shape", way_sel, e.alloc);
        chk(rep_over == (e.alloc && e.cls == 2'b10), "R6 replica overwrite flag", rep_over,
            (e.alloc && e.cls == 2'b10));
        chk(disp_valid == (e.alloc && e.cls != 2'b00), "R9 displace valid", disp_valid,
            (e.alloc && e.cls != 2'b00));
        if (e.alloc && e.cls != 2'b00)
          chk(disp_addr == e.addrs[idx*ADDR_W +: ADDR_W], "R9 displace addr", disp_addr,
              e.addrs[idx*ADDR_W +: ADDR_W]);
        else
          chk(disp_addr == '0, "R9 displace addr idle", disp_addr, 0);
        seen = seen | way_sel;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    logic [WAYS-1:0] v, r, s;
    string tag;
    repeat (3) @(negedge clk);
    chk(dec_valid == 1'b0, "R1 reset dec_valid", dec_valid, 0);
    chk(alloc == 1'b0 && way_sel == '0, "R8 reset select", way_sel, 0);
    rst_n = 1'b1;
    idle(2);

    // R4: all empty, several requests to see the start index move (R10)
    seen = '0;
    for (int k = 0; k < 40; k++) send(1, 3'd5, '0, '0, '0, "R4");
    idle(3);
    chk($countones(seen) >= 2, "R10 distinct ways chosen", $countones(seen), 2);

    // R4: a single invalid way among shared home lines
    send(1, 3'd0, ~(16'h1 << 5), '0, '1, "R4");
    // R5: one unshared home line, the rest replicas
    send(1, 3'd7, '1, ~(16'h1 << 9), '0, "R5");
    // R6: two replicas, the rest shared home lines
    send(1, 3'd1, '1, 16'h1008, ~16'h1008, "R6");
    // R7: every way a shared home line
    send(1, 3'd3, '1, '0, '1, "R7");
    // R2: non-capacity eviction with free ways
    send(0, 3'd4, 16'h00F0, '0, '0, "R2");
    // R3: locally homed line
    send(1, TILE_ID, '0, '0, '0, "R3");
    idle(3);

    // random set states
    for (int k = 0; k < 300; k++) begin
      int mode;
      mode = $urandom_range(0, 3);
      for (int i = 0; i < WAYS; i++) begin
        int c;
        c = $urandom_range(0, 9);
        if (mode == 1 && c < 3) c = 9;
        if (mode >= 2 && c < 6) c = 9;
        v[i] = (c >= 1);
        r[i] = (c >= 4 && c < 7);
        s[i] = (c >= 7) || (c >= 4 && c < 7 && c[0]);
        if (c >= 1 && c < 4) s[i] = 1'b0;
      end
      if (mode == 3) begin v = '1; r = '0; s = '1; end
      if (v != '1) tag = "R4";
      else if ((v & ~r & ~s) != '0) tag = "R5";
      else if ((v & r) != '0) tag = "R6";
      else tag = "R7";
      send(1, 3'(k % 8 == 2 ? 3 : k % 8), v, r, s, tag);
      if (k % 7 == 0) idle(1);
    end
    idle(4);
    chk(q.size() == 0, "R1 decisions outstanding", q.size(), 0);
    summary();
  end
endmodule